// File: doc/BRIEF.md
# PHY management register controller

This block gives software a two-register window onto a model of a PHY's management register file. The file holds 32 registers of 16 bits each, and each register starts from a fixed value at reset. Software sets up an access by writing one control word. That word carries a start flag, an operation code, a register index and, for writes, the 16-bit value. A separate 32-bit data register is where read results land, and software can also load it directly.

Every operation finishes on the same clock edge that accepts the control write. The start flag therefore never shows as set when the control register is read back. A read of the data register always reports the idle flag as set. Any PHY write also forces the link-status bit of PHY register 1 to 1, and this holds even when that write targets register 1 and clears the bit.

The bus port is a plain request channel with no back-pressure. The block accepts every request whose `req_valid` is high, in the cycle it is presented. Nothing ever stalls the requester, and there is no ready signal. A read request produces `rsp_valid` with its data exactly one cycle later. Write requests produce no response. The port has no byte enables, so every write stores the full 32-bit word.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset, the control register reads 0 and the data register reads 0x00010000. The PHY registers hold reg0=0x1000, reg1=0x796D, reg2=0x001C, reg3=0xC916, reg4=0x01E1, reg5=0x45E1, reg9=0x0300 and reg10=0x7C00. Every other PHY register holds 0.
- R2: The control register sits at byte offset 0x00 and the data register at 0x04. A read of any other offset returns 0. A write to any other offset changes neither register and no PHY register.
- R3: A read request accepted at a clock edge raises `rsp_valid`, with `rsp_rdata`, at that same edge, so both are visible for one cycle. `rsp_valid` is low in every other cycle.
- R4: Bit 31 of the control word is the start flag. The control register stores the written word with bit 31 cleared, so a readback shows bit 31 low and every other bit as written.
- R5: Bits 27:26 of the control word are the operation code: 01 is a PHY write and 10 is a PHY read. Codes 00 and 11, and any control write with bit 31 low, change neither the PHY registers nor the data register.
- R6: A PHY write, started with bit 31 set and code 01, stores bits 15:0 of the control word into the PHY register that bits 20:16 select.
- R7: A PHY read, started with bit 31 set and code 10, copies the selected PHY register into bits 15:0 of the data register and leaves bits 31:16 unchanged.
- R8: A write to the data register stores all 32 bits. Every read of the data register returns bit 16 forced to 1.
- R9: After any PHY write, bit 2 of PHY register 1 is 1, including after a write to register 1 that clears that bit.
- R10: An operation completes at the edge that accepts its control write. A data register read issued in the very next cycle already returns the result of a PHY read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W (32) | Read data |

## Verification
The case hardest to reach from the ports is the link-status bit of register 1. Its reset value already has the bit set, so a bench that only watches it can never tell forcing from keeping. The stimulus first writes register 1 with a value whose bit 2 is clear and reads it back to expect 0x0004. It then writes another register and reads register 1 again. A PHY read placed directly after the start write, together with data words whose upper half is nonzero, shows that the result arrives in the same cycle and that bits 31:16 are preserved. Seeded random control words mix every operation code with start flags both high and low, and their results are checked against a bench model.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int START_POS = 31;
  localparam int OP_LO     = 26;
  localparam int IDX_LO    = 16;
  localparam int IDLE_POS  = 16;
  localparam int LINK_REG  = 1;
  localparam int LINK_POS  = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSVD = 2'b11
  } mgmt_op_e;

  function automatic logic [15:0] phy_reset_value(input int unsigned idx);
    case (idx)
      0:       phy_reset_value = 16'h1000;
      1:       phy_reset_value = 16'h796D;
      2:       phy_reset_value = 16'h001C;
      3:       phy_reset_value = 16'hC916;
      4:       phy_reset_value = 16'h01E1;
      5:       phy_reset_value = 16'h45E1;
      9:       phy_reset_value = 16'h0300;
      10:      phy_reset_value = 16'h7C00;
      default: phy_reset_value = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/phy_mgmt_bus_if.sv
module phy_mgmt_bus_if #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] data_q,
  output logic              ctrl_we,
  output logic              data_we,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  import phy_mgmt_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);
  localparam logic [DATA_W-1:0] IDLE_MASK = DATA_W'(1) << IDLE_POS;

  logic hit_ctrl, hit_data, rd_req;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = (req_addr == CTRL_OFS);
  assign hit_data = (req_addr == DATA_OFS);
  assign rd_req   = req_valid && !req_write;
  assign ctrl_we  = req_valid && req_write && hit_ctrl;
  assign data_we  = req_valid && req_write && hit_data;

  always_comb begin
    if (hit_ctrl)      rd_mux = ctrl_q;
    else if (hit_data) rd_mux = data_q | IDLE_MASK;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/phy_mgmt_cmd_unit.sv
module phy_mgmt_cmd_unit #(
  parameter int DATA_W = 32,
  parameter int PHY_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wval,
  input  logic [PHY_W-1:0]  phy_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] data_q,
  output logic              phy_we,
  output logic [IDX_W-1:0]  phy_idx,
  output logic [PHY_W-1:0]  phy_wdata
);
  import phy_mgmt_pkg::*;

  localparam logic [DATA_W-1:0] START_MASK = DATA_W'(1) << START_POS;

  mgmt_op_e op;
  logic     fire, rd_fire;

  assign op        = mgmt_op_e'(wval[OP_LO +: 2]);
  assign fire      = ctrl_we && wval[START_POS];
  assign phy_we    = fire && (op == OP_WR);
  assign rd_fire   = fire && (op == OP_RD);
  assign phy_idx   = wval[IDX_LO +: IDX_W];
  assign phy_wdata = wval[PHY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wval & ~START_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_we) begin
      data_q <= wval;
    end else if (rd_fire) begin
      data_q[PHY_W-1:0] <= phy_rdata;
    end
  end

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile #(
  parameter int NREG  = 32,
  parameter int PHY_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [PHY_W-1:0] wdata,
  output logic [PHY_W-1:0] rdata,
  output logic             link_flag
);
  import phy_mgmt_pkg::*;

  logic [NREG-1:0][PHY_W-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [PHY_W-1:0] q;
    logic             hit;
    assign hit = we && (idx == IDX_W'(g));
    assign mem[g] = q;

    if (g == LINK_REG) begin : g_link
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= PHY_W'(phy_reset_value(g));
        end else if (we) begin
          q <= (hit ? wdata : q) | (PHY_W'(1) << LINK_POS);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= PHY_W'(phy_reset_value(g));
        end else if (hit) begin
          q <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IDX_W'(i)) rdata = mem[i];
    end
  end

  assign link_flag = mem[LINK_REG][LINK_POS];

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int PHY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int IDX_W = $clog2(NREG);

  logic              ctrl_we, data_we, phy_we, link_flag;
  logic [DATA_W-1:0] ctrl_q, data_q;
  logic [IDX_W-1:0]  phy_idx;
  logic [PHY_W-1:0]  phy_wdata, phy_rdata;

  phy_mgmt_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .ctrl_q(ctrl_q), .data_q(data_q),
    .ctrl_we(ctrl_we), .data_we(data_we),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  phy_mgmt_cmd_unit #(.DATA_W(DATA_W), .PHY_W(PHY_W), .IDX_W(IDX_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .data_we(data_we), .wval(req_wdata),
    .phy_rdata(phy_rdata),
    .ctrl_q(ctrl_q), .data_q(data_q),
    .phy_we(phy_we), .phy_idx(phy_idx), .phy_wdata(phy_wdata)
  );

  phy_mgmt_regfile #(.NREG(NREG), .PHY_W(PHY_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(phy_we), .idx(phy_idx), .wdata(phy_wdata),
    .rdata(phy_rdata), .link_flag(link_flag)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wr_start,
  input logic [1:0]        wr_op,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] data_q,
  input logic              link_flag
);
  logic rd, rd_ctrl, rd_data, rd_other, cw;
  assign rd       = req_valid && !req_write;
  assign rd_ctrl  = rd && (req_addr == ADDR_W'(0));
  assign rd_data  = rd && (req_addr == ADDR_W'(4));
  assign rd_other = rd && !(req_addr == ADDR_W'(0)) && !(req_addr == ADDR_W'(4));
  assign cw       = req_valid && req_write && (req_addr == ADDR_W'(0));

  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> !rsp_rdata[31]);
  // R8
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> rsp_rdata[16]);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> (rsp_rdata == '0));
  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && wr_start && wr_op == 2'b10) |=> (data_q[31:16] == $past(data_q[31:16])));
  // R5
  noop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && (!wr_start || wr_op == 2'b00 || wr_op == 2'b11)) |=> $stable(data_q));
  // R9
  link_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && wr_start && wr_op == 2'b01) |=> link_flag);

endmodule

bind phy_mgmt_ctrl phy_mgmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .wr_start(req_wdata[31]), .wr_op(req_wdata[27:26]),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .data_q(data_q), .link_flag(link_flag)
);

// File: tb/sim_phy_mgmt_ctrl.sv
module sim_phy_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;

  logic [15:0] phy_m [32];
  logic [31:0] ctrl_m, data_m;

  always #5 clk = ~clk;

  phy_mgmt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [15:0] rst_val(input int i);
    case (i)
      0: return 16'h1000;  1: return 16'h796D;  2: return 16'h001C;
      3: return 16'hC916;  4: return 16'h01E1;  5: return 16'h45E1;
      9: return 16'h0300; 10: return 16'h7C00;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return ctrl_m;
    if (a == 8'h04) return data_m | 32'h0001_0000;
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] w);
    if (a == 8'h04) data_m = w;
    else if (a == 8'h00) begin
      ctrl_m = w & 32'h7FFF_FFFF;
      if (w[31]) begin
        if (w[27:26] == 2'b01) begin
          phy_m[w[20:16]] = w[15:0];
          phy_m[1][2] = 1'b1;
        end else if (w[27:26] == 2'b10) begin
          data_m[15:0] = phy_m[w[20:16]];
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] w);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, w);
  endtask

  task automatic bus_read(input logic [7:0] a, input string req);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
    chk(req, rsp_rdata, exp_read(a));
  endtask

  task automatic read_phy(input int idx, input string req);
    bus_write(8'h00, 32'h8800_0000 | (32'(idx) << 16));
    bus_read(8'h04, req);
  endtask

  task automatic write_phy(input int idx, input logic [15:0] v);
    bus_write(8'h00, 32'h8400_0000 | (32'(idx) << 16) | 32'(v));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) phy_m[i] = rst_val(i);
    ctrl_m = '0; data_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and R3 idle response line
    chk("R3 idle", {31'h0, rsp_valid}, 32'h0);
    bus_read(8'h00, "R1 ctrl reset");
    bus_read(8'h04, "R1 data reset");
    for (int i = 0; i < 32; i++) read_phy(i, "R1 phy reset");

    // R4 start flag cleared, R5 reserved code has no effect
    bus_write(8'h04, 32'h1234_5678);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, "R4 start cleared");
    bus_read(8'h04, "R5 code 11 no effect");
    bus_write(8'h00, 32'h8003_ABCD);
    bus_read(8'h04, "R5 code 00 no effect");
    bus_write(8'h00, 32'h0405_BEEF);
    read_phy(5, "R5 no start no write");

    // R6 write/read, R9 link bit forced
    write_phy(1, 16'h0000);
    read_phy(1, "R9 link forced on reg1");
    write_phy(31, 16'hBEEF);
    read_phy(31, "R6 reg31");
    read_phy(1, "R9 link after other write");

    // R7 upper half preserved, R10 result next cycle
    bus_write(8'h04, 32'hA5A5_0000);
    bus_write(8'h00, 32'h881F_0000);
    bus_read(8'h04, "R10 R7 immediate read upper kept");

    // R8 data write stores all bits, bit16 forced
    bus_write(8'h04, 32'h0000_0000);
    bus_read(8'h04, "R8 idle forced");
    bus_write(8'h04, 32'hFFFE_FFFF);
    bus_read(8'h04, "R8 full word");

    // R2 unmapped offsets
    bus_write(8'h08, 32'h8400_FFFF);
    bus_write(8'h02, 32'hDEAD_BEEF);
    bus_read(8'h00, "R2 ctrl untouched");
    bus_read(8'h04, "R2 data untouched");
    bus_read(8'h08, "R2 unmapped zero");
    bus_read(8'hFC, "R2 unmapped zero high");
    read_phy(0, "R2 phy0 untouched");

    // random mix checked against the model
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4) begin
        w = $urandom();
        w[25:21] = 5'd0;
        if ($urandom_range(0, 3) != 0) w[31] = 1'b1;
        bus_write(8'h00, w);
      end else if (sel < 5) begin
        bus_write(8'h04, $urandom());
      end else if (sel < 6) begin
        bus_write(8'($urandom_range(8, 255)), $urandom());
      end else if (sel < 9) begin
        bus_read(($urandom_range(0, 1) != 0) ? 8'h04 : 8'h00, "R6 R7 random");
      end else begin
        bus_read(8'($urandom_range(5, 255)), "R2 random unmapped");
      end
    end
    for (int i = 0; i < 32; i++) read_phy(i, "R6 final sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule